// File: doc/BRIEF.md
# Single-Input Systolic Priority Queue

This block keeps a set of keyed entries, each an unsigned key with a tag, in a linear chain of registers and always shows the entry with the largest key at its head. In any clock cycle it accepts one new entry or hands out the current best one. The work per operation is a one-slot shift of the whole chain followed by one layer of compare-exchange cells between fixed neighbouring slot pairs. No operation ever sorts the whole chain, so the cycle time does not depend on how deep the chain is.

Slot 0 is the port. A push writes the new entry into slot 0 and moves every stored entry one slot deeper. A pop takes slot 0 out, moves every entry one slot toward the head and fills the tail with an empty marker. After either shift, the slot pairs (0,1), (2,3), (4,5) and so on are exchanged wherever the deeper slot holds the larger key. This keeps the k-th best entry within slots 0 to 2k-2, so the best entry always sits in slot 0. An empty slot holds an all-zero entry whose valid bit is clear. It loses every comparison and drifts toward the tail. An occupancy counter drives the full and empty flags and an overflow pulse.

Top module: `sys_prio_queue`

## Requirements
- R1: After reset the queue is empty: `count_o`=0, `empty_o`=1, `full_o`=0, `head_vld_o`=0, `out_vld_o`=0, `ovf_o`=0.
- R2: Whenever the queue holds at least one entry, `head_vld_o`=1 and `head_key_o` equals the largest stored key. When the queue is empty, `head_vld_o`=0.
- R3: A pop (`ext_i`=1) on a non-empty queue presents the largest stored key and the tag of an entry with that key on `out_key_o`/`out_tag_o` with `out_vld_o`=1 in the next cycle. That entry is removed and `count_o` drops by one.
- R4: A push (`ins_i`=1, `ext_i`=0) on a non-full queue stores the entry in one cycle and raises `count_o` by one. A push is accepted in every consecutive cycle.
- R5: Entries are exchanged only on a strictly larger key. Pushing a key equal to the head key therefore makes the new entry the head, and the next pop returns its tag.
- R6: A pop on an empty queue gives `out_vld_o`=0, `out_key_o`=0 and `out_tag_o`=0 in the next cycle and leaves `count_o` at 0.
- R7: A push into a full queue keeps the new entry and discards the entry that falls out of the last slot. `count_o` stays at DEPTH and `ovf_o` is 1 for exactly the next cycle.
- R8: When `ins_i` and `ext_i` are both 1, only the pop is performed and the pushed entry is ignored.
- R9: `full_o`=1 exactly when `count_o`=DEPTH, and `empty_o`=1 exactly when `count_o`=0.
- R10: In a cycle with neither strobe, the head, the count and the stored set stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_i | input | 1 | Push strobe |
| ins_key_i | input | KEY_W | Key of the pushed entry |
| ins_tag_i | input | TAG_W | Tag of the pushed entry |
| ext_i | input | 1 | Pop strobe |
| out_vld_o | output | 1 | Pop result valid, one cycle after `ext_i` |
| out_key_o | output | KEY_W | Popped key |
| out_tag_o | output | TAG_W | Popped tag |
| head_vld_o | output | 1 | Slot 0 holds an entry |
| head_key_o | output | KEY_W | Key in slot 0 |
| head_tag_o | output | TAG_W | Tag in slot 0 |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |
| count_o | output | $clog2(DEPTH+1) | Number of stored entries |
| ovf_o | output | 1 | One-cycle pulse after a push into a full queue |

## Verification
The bench builds the queue with DEPTH=7, KEY_W=4 and TAG_W=8. The odd depth leaves the tail slot outside every compare pair. The 4-bit key makes equal keys frequent in random traffic, so the tie rule and tag handling on duplicates are exercised often. The shallow chain lets random push/pop mixes reach the full and empty states many times. A directed push into the full queue then shows that the overflow drop never costs the new maximum.

// File: rtl/spq_pkg.sv
package spq_pkg;
  typedef enum logic [1:0] {
    SPQ_IDLE = 2'd0,
    SPQ_PUSH = 2'd1,
    SPQ_POP  = 2'd2
  } spq_op_e;
endpackage

// File: rtl/spq_rst_sync.sv
module spq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/spq_cmpx.sv
// Compare-exchange cell: the upper (lower-index) slot keeps the larger
// valid key; equal keys are left in place.
module spq_cmpx #(
  parameter int KEY_W = 8,
  parameter int TAG_W = 8,
  localparam int EW = 1 + KEY_W + TAG_W
) (
  input  logic [EW-1:0] up_i,
  input  logic [EW-1:0] dn_i,
  output logic [EW-1:0] up_o,
  output logic [EW-1:0] dn_o
);
  logic             up_v, dn_v;
  logic [KEY_W-1:0] up_k, dn_k;
  logic             swap;

  always_comb begin
    up_v = up_i[EW-1];
    dn_v = dn_i[EW-1];
    up_k = up_i[EW-2 -: KEY_W];
    dn_k = dn_i[EW-2 -: KEY_W];
    swap = dn_v && (!up_v || (dn_k > up_k));
    up_o = swap ? dn_i : up_i;
    dn_o = swap ? up_i : dn_i;
  end
endmodule

// File: rtl/spq_array.sv
module spq_array
  import spq_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int KEY_W = 8,
  parameter int TAG_W = 8,
  localparam int EW = 1 + KEY_W + TAG_W,
  localparam int NPAIR = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  spq_op_e       op_i,
  input  logic [EW-1:0] new_i,
  output logic [EW-1:0] head_o
);
  logic [EW-1:0] slot_q  [DEPTH];
  logic [EW-1:0] shift_c [DEPTH];
  logic [EW-1:0] order_c [DEPTH];
  logic          load;

  // shift stage
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      unique case (op_i)
        SPQ_PUSH: shift_c[j] = (j == 0) ? new_i : slot_q[(j == 0) ? 0 : j - 1];
        SPQ_POP:  shift_c[j] = (j == DEPTH - 1) ? '0 : slot_q[(j == DEPTH - 1) ? j : j + 1];
        default:  shift_c[j] = slot_q[j];
      endcase
    end
  end

  // one layer of pairwise compare-exchange
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    spq_cmpx #(.KEY_W(KEY_W), .TAG_W(TAG_W)) u_cmpx (
      .up_i (shift_c[2*p]),
      .dn_i (shift_c[2*p+1]),
      .up_o (order_c[2*p]),
      .dn_o (order_c[2*p+1])
    );
  end

  if ((DEPTH % 2) == 1) begin : g_tail
    assign order_c[DEPTH-1] = shift_c[DEPTH-1];
  end

  assign load = (op_i != SPQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) slot_q[j] <= '0;
    end else if (load) begin
      for (int j = 0; j < DEPTH; j++) slot_q[j] <= order_c[j];
    end
  end

  assign head_o = slot_q[0];
endmodule

// File: rtl/spq_occupancy.sv
module spq_occupancy
  import spq_pkg::*;
#(
  parameter int DEPTH = 15,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  spq_op_e          op_i,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = 1'b0;
    cnt_en = 1'b0;
    unique case (op_i)
      SPQ_PUSH: begin
        if (cnt_q == CNT_MAX) begin
          ovf_d = 1'b1;
        end else begin
          cnt_d  = cnt_q + CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      SPQ_POP: begin
        cnt_d  = cnt_q - CNT_ONE;
        cnt_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/sys_prio_queue.sv
module sys_prio_queue
  import spq_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int KEY_W = 8,
  parameter int TAG_W = 8,
  localparam int EW = 1 + KEY_W + TAG_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_i,
  input  logic [KEY_W-1:0] ins_key_i,
  input  logic [TAG_W-1:0] ins_tag_i,
  input  logic             ext_i,
  output logic             out_vld_o,
  output logic [KEY_W-1:0] out_key_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic             head_vld_o,
  output logic [KEY_W-1:0] head_key_o,
  output logic [TAG_W-1:0] head_tag_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic          rst_s;
  spq_op_e       op;
  logic [EW-1:0] head;
  logic [EW-1:0] new_ent;
  logic          res_vld_q, res_vld_d;
  logic [EW-1:0] res_q;
  logic          res_en;

  spq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  // pop wins over push; a pop on an empty queue does nothing to state
  always_comb begin
    if (ext_i) op = empty_o ? SPQ_IDLE : SPQ_POP;
    else if (ins_i) op = SPQ_PUSH;
    else op = SPQ_IDLE;
  end

  assign new_ent = {1'b1, ins_key_i, ins_tag_i};

  spq_array #(.DEPTH(DEPTH), .KEY_W(KEY_W), .TAG_W(TAG_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_s),
    .op_i   (op),
    .new_i  (new_ent),
    .head_o (head)
  );

  spq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk     (clk),
    .rst_n   (rst_s),
    .op_i    (op),
    .count_o (count_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (ovf_o)
  );

  // pop result register; an empty head is the all-zero marker
  always_comb begin
    res_en    = ext_i;
    res_vld_d = ext_i && !empty_o;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_vld_q <= 1'b0;
      res_q     <= '0;
    end else begin
      res_vld_q <= res_vld_d;
      if (res_en) res_q <= head;
    end
  end

  assign out_vld_o  = res_vld_q;
  assign out_key_o  = res_q[EW-2 -: KEY_W];
  assign out_tag_o  = res_q[TAG_W-1:0];
  assign head_vld_o = head[EW-1];
  assign head_key_o = head[EW-2 -: KEY_W];
  assign head_tag_o = head[TAG_W-1:0];
endmodule

// File: rtl/sys_prio_queue_chk.sv
module sys_prio_queue_chk #(
  parameter int DEPTH = 15,
  parameter int KEY_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_i,
  input logic             ext_i,
  input logic [KEY_W-1:0] ins_key_i,
  input logic             head_vld_o,
  input logic [KEY_W-1:0] head_key_o,
  input logic             out_vld_o,
  input logic [KEY_W-1:0] out_key_o,
  input logic             full_o,
  input logic             empty_o,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !head_vld_o); // R2
  AST_FILLED_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_o |-> head_vld_o); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= DEPTH_C); // R9
  AST_POP_FROM_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_i && !empty_o) |=> (out_vld_o && out_key_o == $past(head_key_o))); // R3
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_i && empty_o) |=> (!out_vld_o && $stable(count_o))); // R6
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_i && !ext_i && !full_o) |=> (count_o == $past(count_o) + ONE_C)); // R4
  AST_PUSH_HEAD_GE: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_i && !ext_i) |=> (head_vld_o && head_key_o >= $past(ins_key_i))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_i && !ext_i && full_o) |=> (ovf_o && full_o)); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> ($past(ins_i) && !$past(ext_i) && $past(full_o))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_i && !ext_i) |=> ($stable(head_key_o) && $stable(count_o))); // R10
  AST_BOTH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_i && ext_i && !empty_o) |=> (count_o == $past(count_o) - ONE_C)); // R8
endmodule

bind sys_prio_queue sys_prio_queue_chk #(
  .DEPTH (DEPTH),
  .KEY_W (KEY_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .ins_i      (ins_i),
  .ext_i      (ext_i),
  .ins_key_i  (ins_key_i),
  .head_vld_o (head_vld_o),
  .head_key_o (head_key_o),
  .out_vld_o  (out_vld_o),
  .out_key_o  (out_key_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .count_o    (count_o),
  .ovf_o      (ovf_o)
);

// File: tb/sys_prio_queue_test.sv
`timescale 1ns/1ps
module sys_prio_queue_test;
  localparam int DEPTH = 7;
  localparam int KEY_W = 4;
  localparam int TAG_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ins_i, ext_i;
  logic [KEY_W-1:0] ins_key_i;
  logic [TAG_W-1:0] ins_tag_i;
  logic             out_vld_o, head_vld_o, full_o, empty_o, ovf_o;
  logic [KEY_W-1:0] out_key_o, head_key_o;
  logic [TAG_W-1:0] out_tag_o, head_tag_o;
  logic [CNT_W-1:0] count_o;

  int checks = 0;
  int errors = 0;

  // reference set
  int mkey [DEPTH];
  int mtag [DEPTH];
  int mcnt = 0;
  int tag_seq = 1;

  always #2.5 clk = ~clk;

  sys_prio_queue #(.DEPTH(DEPTH), .KEY_W(KEY_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .ins_i(ins_i), .ins_key_i(ins_key_i),
    .ins_tag_i(ins_tag_i), .ext_i(ext_i), .out_vld_o(out_vld_o),
    .out_key_o(out_key_o), .out_tag_o(out_tag_o), .head_vld_o(head_vld_o),
    .head_key_o(head_key_o), .head_tag_o(head_tag_o), .full_o(full_o),
    .empty_o(empty_o), .count_o(count_o), .ovf_o(ovf_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_max();
    int m = -1;
    for (int j = 0; j < mcnt; j++) if (mkey[j] > m) m = mkey[j];
    return m;
  endfunction

  function automatic int model_find(input int k, input int t);
    for (int j = 0; j < mcnt; j++) if (mkey[j] == k && mtag[j] == t) return j;
    return -1;
  endfunction

  task automatic model_remove(input int idx);
    for (int j = idx; j < mcnt - 1; j++) begin
      mkey[j] = mkey[j+1];
      mtag[j] = mtag[j+1];
    end
    mcnt--;
  endtask

  task automatic check_state();
    check(count_o == CNT_W'(mcnt), "R4 count", int'(count_o), mcnt);
    check(full_o == (mcnt == DEPTH) && empty_o == (mcnt == 0), "R9 flags",
          int'({full_o, empty_o}), int'({mcnt == DEPTH, mcnt == 0}));
    if (mcnt > 0) check(head_vld_o && int'(head_key_o) == model_max(), "R2 head",
                        int'(head_key_o), model_max());
    else check(!head_vld_o, "R2 empty head", int'(head_vld_o), 0);
  endtask

  // one operation per cycle; inputs set at negedge, results sampled at the next negedge
  task automatic step(input bit i, input bit e, input int k);
    int  exp_max;
    int  t;
    int  idx;
    bit  was_full;
    t = tag_seq;
    tag_seq = (tag_seq % 250) + 1;
    exp_max = model_max();
    was_full = (mcnt == DEPTH);
    ins_i = i; ext_i = e; ins_key_i = KEY_W'(k); ins_tag_i = TAG_W'(t);
    @(negedge clk);
    ins_i = 1'b0; ext_i = 1'b0;
    if (e) begin
      if (mcnt > 0) begin
        check(out_vld_o && int'(out_key_o) == exp_max, i ? "R8 pop wins" : "R3 pop max",
              int'(out_key_o), exp_max);
        idx = model_find(int'(out_key_o), int'(out_tag_o));
        check(idx >= 0, "R3 pop tag", int'(out_tag_o), idx);
        if (idx >= 0) model_remove(idx);
      end else begin
        check(!out_vld_o && out_key_o == '0 && out_tag_o == '0, "R6 empty pop",
              int'(out_vld_o), 0);
      end
    end else if (i) begin
      check(ovf_o == was_full, "R7 ovf", int'(ovf_o), int'(was_full));
      if (!was_full) begin
        mkey[mcnt] = k; mtag[mcnt] = t; mcnt++;
      end
    end else begin
      check(!out_vld_o && !ovf_o, "R10 idle", int'(out_vld_o), 0);
    end
    check_state();
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int prev;
    int r;
    void'($urandom(32'd4711));
    ins_i = 1'b0; ext_i = 1'b0; ins_key_i = '0; ins_tag_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(count_o == '0 && empty_o && !full_o && !head_vld_o && !out_vld_o && !ovf_o,
          "R1 reset", int'(count_o), 0);

    // R6 pop on empty
    step(1'b0, 1'b1, 0);

    // R5 tie: the later equal key becomes head
    step(1'b1, 1'b0, 9);
    prev = tag_seq;
    step(1'b1, 1'b0, 9);
    check(int'(head_tag_o) == prev, "R5 tie head tag", int'(head_tag_o), prev);
    step(1'b0, 1'b1, 0);
    check(int'(out_tag_o) == prev, "R5 tie pop tag", int'(out_tag_o), prev);
    step(1'b0, 1'b1, 0);

    // R8 simultaneous strobes on a filled queue
    step(1'b1, 1'b0, 3);
    step(1'b1, 1'b1, 15);
    check(count_o == '0, "R8 push ignored", int'(count_o), 0);

    // R10 idle cycles
    step(1'b1, 1'b0, 6);
    step(1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    step(1'b0, 1'b1, 0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom_range(99));
      if (r < 50 && mcnt < DEPTH) step(1'b1, 1'b0, int'($urandom_range(15)));
      else if (r < 92) step(1'b0, 1'b1, 0);
      else if (r < 96) step(1'b1, 1'b1, int'($urandom_range(15)));
      else step(1'b0, 1'b0, 0);
    end

    // R7 push into a full queue with a new maximum
    while (mcnt > 0) step(1'b0, 1'b1, 0);
    for (int j = 1; j <= DEPTH; j++) step(1'b1, 1'b0, j);
    check(full_o, "R9 full", int'(full_o), 1);
    ins_i = 1'b1; ext_i = 1'b0; ins_key_i = KEY_W'(15); ins_tag_i = TAG_W'(200);
    @(negedge clk);
    ins_i = 1'b0;
    check(ovf_o && count_o == CNT_W'(DEPTH), "R7 overflow pulse", int'(ovf_o), 1);
    check(head_key_o == KEY_W'(15) && head_tag_o == TAG_W'(200), "R7 new kept",
          int'(head_key_o), 15);
    @(negedge clk);
    check(!ovf_o, "R7 pulse width", int'(ovf_o), 0);
    prev = 16;
    for (int j = 0; j < DEPTH; j++) begin
      ext_i = 1'b1;
      @(negedge clk);
      ext_i = 1'b0;
      if (j == 0) check(out_key_o == KEY_W'(15), "R7 first out", int'(out_key_o), 15);
      check(out_vld_o && int'(out_key_o) <= prev, "R3 drain order", int'(out_key_o), prev);
      prev = int'(out_key_o);
    end
    check(empty_o && count_o == '0, "R9 drained", int'(count_o), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule